// File: doc/BRIEF.md
# YCbCr 4:2:0 Pixel Packer

The packer takes a stream of 4:2:0 video pixels, one pixel per transfer, and builds a packed bus. Each output word holds one chroma sample and the luma of two horizontally adjacent pixels. Each input pixel carries a luma value and both chroma components. The packer uses only the chroma of the even pixel of each pair. It picks Cb on one line and Cr on the next, so over a line pair both components are sent at each horizontal position while luma is sent on every line. A line therefore takes half as many words as it has pixels.

The source marks the first pixel of a frame and the last pixel of each line. A static 2-bit input sets the component depth. The output comes from a single register slot with a valid/ready handshake and carries two markers, one for the first word of a line and one for the first word of a frame. When a line has an odd number of pixels, the packer sends the last pixel with a zero second luma and raises a sticky error flag.

Top module: `ycc420_packer`

## Requirements
- R1: At depth code 3 (16-bit components), an output word has the chroma sample in bits 47:32, the luma of the even pixel n in bits 31:16 and the luma of pixel n+1 in bits 15:0.
- R2: The depth codes 0, 1, 2 and 3 select 8, 10, 12 and 16-bit components. The word then uses the low 3·D bits, in the order chroma, luma n, luma n+1 from the top down. Each field is the low D bits of its input, and the output bits above 3·D are zero.
- R3: The chroma field carries Cb (in_cb) on every word of the first line after a pixel marked by in_sof. The component then alternates between Cb and Cr (in_cr) after each pixel marked by in_eol.
- R4: The chroma in a word comes from the even pixel n of the pair, not from pixel n+1.
- R5: The packer produces exactly one output word for every two accepted pixels of a line, and one for a final unpaired pixel. It drops and duplicates no word.
- R6: out_sol is 1 on the first word of each line, including the first word after reset, and 0 on every other word.
- R7: out_sof is 1 only on the word whose even pixel carried in_sof.
- R8: A line with an odd pixel count ends in a word whose luma n+1 field is zero. After that word is accepted, err_odd is 1 and stays 1 until reset. err_odd stays 0 while every line is even.
- R9: While out_valid is 1 and out_ready is 0, in_ready is 0 and the output word and its markers stay unchanged.
- R10: After reset, out_valid is 0, err_odd is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_depth | input | 2 | Component depth code: 0=8, 1=10, 2=12, 3=16 bits; static |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Packer can accept a pixel |
| in_y | input | 16 | Luma of the pixel, low bits used |
| in_cb | input | 16 | Cb of the pixel, low bits used |
| in_cr | input | 16 | Cr of the pixel, low bits used |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_eol | input | 1 | Pixel is the last of its line |
| out_valid | output | 1 | Packed word valid |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 48 | Packed word: chroma, luma n, luma n+1 |
| out_sol | output | 1 | Word is the first of a line |
| out_sof | output | 1 | Word is the first of a frame |
| err_odd | output | 1 | Sticky: a line had an odd pixel count |

## Verification
A wrong pairing state, such as a lost or extra held pixel, shows up at the next output word. The luma fields arrive shifted by one pixel, and the sequence of line-start markers drifts away from the reference at the next line end. A wrong chroma-select state shows up as Cb and Cr swapped on every word of a line. This error is visible on the first word after an end-of-line or start-of-frame marker. Backpressure faults appear as a word that changes while it is stalled, or as a pixel accepted while the slot is full. Either fault leaves the reference word queue out of step for the rest of the run.

// File: rtl/ycc420_pkg.sv
package ycc420_pkg;

    localparam int COMP_W  = 16;
    localparam int WORD_W  = 3 * COMP_W;
    localparam int N_DEPTH = 4;

    typedef enum logic [1:0] {
        DEPTH_8  = 2'd0,
        DEPTH_10 = 2'd1,
        DEPTH_12 = 2'd2,
        DEPTH_16 = 2'd3
    } depth_e;

    typedef struct packed {
        logic [COMP_W-1:0] y;
        logic [COMP_W-1:0] cb;
        logic [COMP_W-1:0] cr;
        logic              sof;
        logic              eol;
    } pixel_t;

    typedef struct packed {
        logic [COMP_W-1:0] c;
        logic [COMP_W-1:0] ya;
        logic [COMP_W-1:0] yb;
        logic              sol;
        logic              sof;
    } pair_t;

    function automatic int depth_bits(input int code);
        case (code)
            0:       return 8;
            1:       return 10;
            2:       return 12;
            default: return COMP_W;
        endcase
    endfunction

endpackage

// File: rtl/ycc420_pair_builder.sv
module ycc420_pair_builder
    import ycc420_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   acc,
    input  pixel_t pix,
    output logic   emit,
    output pair_t  pair,
    output logic   err_odd
);

    logic              have_q;
    logic              line_cr_q;
    logic              sol_pend_q;
    logic [COMP_W-1:0] ya_q;
    logic [COMP_W-1:0] c_q;
    logic              sol_q;
    logic              sof_q;
    logic              err_q;

    logic              cur_cr;
    logic [COMP_W-1:0] cur_c;

    always_comb begin
        cur_cr = pix.sof ? 1'b0 : line_cr_q;
        cur_c  = cur_cr ? pix.cr : pix.cb;
        emit   = acc && (have_q || pix.eol);
        if (have_q) begin
            pair.c   = c_q;
            pair.ya  = ya_q;
            pair.yb  = pix.y;
            pair.sol = sol_q;
            pair.sof = sof_q;
        end else begin
            pair.c   = cur_c;
            pair.ya  = pix.y;
            pair.yb  = '0;
            pair.sol = sol_pend_q || pix.sof;
            pair.sof = pix.sof;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_q     <= 1'b0;
            line_cr_q  <= 1'b0;
            sol_pend_q <= 1'b1;
            err_q      <= 1'b0;
            ya_q       <= '0;
            c_q        <= '0;
            sol_q      <= 1'b0;
            sof_q      <= 1'b0;
        end else if (acc) begin
            if (!have_q) begin
                if (pix.eol) begin
                    err_q      <= 1'b1;
                    line_cr_q  <= !cur_cr;
                    sol_pend_q <= 1'b1;
                end else begin
                    have_q     <= 1'b1;
                    ya_q       <= pix.y;
                    c_q        <= cur_c;
                    sol_q      <= sol_pend_q || pix.sof;
                    sof_q      <= pix.sof;
                    line_cr_q  <= cur_cr;
                    sol_pend_q <= 1'b0;
                end
            end else begin
                have_q <= 1'b0;
                if (pix.eol) begin
                    line_cr_q  <= !line_cr_q;
                    sol_pend_q <= 1'b1;
                end
            end
        end
    end

    assign err_odd = err_q;

    // R8: the odd-line flag never clears without reset
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_odd |=> err_odd);

endmodule

// File: rtl/ycc420_field_pack.sv
module ycc420_field_pack
    import ycc420_pkg::*;
(
    input  depth_e             depth,
    input  pair_t              pair,
    output logic [WORD_W-1:0]  word
);

    logic [WORD_W-1:0] cand [N_DEPTH];

    for (genvar g = 0; g < N_DEPTH; g++) begin : g_depth
        localparam int W = depth_bits(g);
        assign cand[g] = WORD_W'({pair.c[W-1:0], pair.ya[W-1:0], pair.yb[W-1:0]});
    end

    assign word = cand[depth];

endmodule

// File: rtl/ycc420_out_stage.sv
module ycc420_out_stage
    import ycc420_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              sol,
    input  logic              sof,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_sol,
    output logic              out_sof,
    output logic              slot_free
);

    assign slot_free = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sol   <= 1'b0;
            out_sof   <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= word;
            out_sol   <= sol;
            out_sof   <= sof;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R9: a stalled word is held unchanged
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
                                    && $stable(out_sol) && $stable(out_sof));

endmodule

// File: rtl/ycc420_packer.sv
module ycc420_packer
    import ycc420_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_depth,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [COMP_W-1:0] in_y,
    input  logic [COMP_W-1:0] in_cb,
    input  logic [COMP_W-1:0] in_cr,
    input  logic              in_sof,
    input  logic              in_eol,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_sol,
    output logic              out_sof,
    output logic              err_odd
);

    pixel_t            pix;
    pair_t             pair;
    logic              emit;
    logic              acc;
    logic              slot_free;
    logic [WORD_W-1:0] word;

    assign pix      = '{y: in_y, cb: in_cb, cr: in_cr, sof: in_sof, eol: in_eol};
    assign in_ready = slot_free;
    assign acc      = in_valid && slot_free;

    ycc420_pair_builder i_builder (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .pix     (pix),
        .emit    (emit),
        .pair    (pair),
        .err_odd (err_odd)
    );

    ycc420_field_pack i_pack (
        .depth (depth_e'(cfg_depth)),
        .pair  (pair),
        .word  (word)
    );

    ycc420_out_stage i_out (
        .clk       (clk),
        .rst       (rst),
        .load      (emit),
        .word      (word),
        .sol       (pair.sol),
        .sof       (pair.sof),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sol   (out_sol),
        .out_sof   (out_sof),
        .slot_free (slot_free)
    );

    // R7: a frame's first word is also a line's first word
    a_r7_sof_has_sol: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_sof |-> out_sol);

    // R2: nothing above the selected packed width
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data >> (3 * depth_bits(int'(cfg_depth)))) == '0);

endmodule

// File: tb/test_ycc420_packer.sv
module test_ycc420_packer;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  cfg_depth;
    logic        in_valid;
    logic        in_ready;
    logic [15:0] in_y, in_cb, in_cr;
    logic        in_sof, in_eol;
    logic        out_valid;
    logic        out_ready;
    logic [47:0] out_data;
    logic        out_sol, out_sof;
    logic        err_odd;

    always #10 clk = ~clk;

    ycc420_packer i_ycc420_packer (
        .clk(clk), .rst(rst), .cfg_depth(cfg_depth),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
        .in_sof(in_sof), .in_eol(in_eol),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_sol(out_sol), .out_sof(out_sof),
        .err_odd(err_odd)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // stimulus queues
    int qy[$], qcb[$], qcr[$];
    bit qsof[$], qeol[$];
    int pidx = 0;
    bit running = 0;
    int exp_words = 0;
    int got_words = 0;

    // reference model state
    bit          m_have, m_cr, m_nextsol, m_sol0, m_sof0, m_err;
    int          m_y0, m_c0;
    logic [47:0] e_data[$];
    bit          e_sol[$], e_sof[$];

    function automatic logic [47:0] pack_word(input int d, input int c, input int ya, input int yb);
        int w;
        longint mask;
        w = (d == 3) ? 16 : 8 + 2 * d;
        mask = (longint'(1) << w) - 1;
        return 48'(((longint'(c) & mask) << (2 * w)) | ((longint'(ya) & mask) << w) | (longint'(yb) & mask));
    endfunction

    task automatic push_exp(input int c, input int ya, input int yb, input bit s, input bit f);
        e_data.push_back(pack_word(int'(cfg_depth), c, ya, yb));
        e_sol.push_back(s);
        e_sof.push_back(f);
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_have = 0; m_cr = 0; m_nextsol = 1; m_err = 0;
            e_data.delete(); e_sol.delete(); e_sof.delete();
        end else begin
            if (out_valid && out_ready) begin
                got_words++;
                if (e_data.size() == 0) begin
                    chk(0, "R5 unexpected word", longint'(out_data), 0);
                end else begin
                    chk(out_data == e_data[0], "R1/R2/R3/R4 data", longint'(out_data), longint'(e_data[0]));
                    chk(out_sol == e_sol[0], "R6 sol", longint'(out_sol), longint'(e_sol[0]));
                    chk(out_sof == e_sof[0], "R7 sof", longint'(out_sof), longint'(e_sof[0]));
                    void'(e_data.pop_front()); void'(e_sol.pop_front()); void'(e_sof.pop_front());
                end
            end
            if (in_valid && in_ready) begin
                pidx++;
                if (in_sof) begin m_cr = 0; m_nextsol = 1; end
                if (!m_have) begin
                    if (in_eol) begin
                        push_exp(m_cr ? int'(in_cr) : int'(in_cb), int'(in_y), 0, m_nextsol, in_sof);
                        m_err = 1; m_cr = !m_cr; m_nextsol = 1;
                    end else begin
                        m_have = 1; m_y0 = int'(in_y);
                        m_c0 = m_cr ? int'(in_cr) : int'(in_cb);
                        m_sol0 = m_nextsol; m_sof0 = in_sof; m_nextsol = 0;
                    end
                end else begin
                    push_exp(m_c0, m_y0, int'(in_y), m_sol0, m_sof0);
                    m_have = 0;
                    if (in_eol) begin m_cr = !m_cr; m_nextsol = 1; end
                end
            end
        end
    end

    // input and output drive
    always @(negedge clk) begin
        if (running && pidx < qy.size()) begin
            in_valid = ($urandom % 4) != 0;
            in_y  = 16'(qy[pidx]);
            in_cb = 16'(qcb[pidx]);
            in_cr = 16'(qcr[pidx]);
            in_sof = qsof[pidx];
            in_eol = qeol[pidx];
        end else begin
            in_valid = 0;
        end
        out_ready = running ? (($urandom % 3) != 0) : 1'b1;
    end

    // per-cycle port checks away from the edge
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            chk(err_odd == m_err, "R8 err_odd", longint'(err_odd), longint'(m_err));
            if (out_valid && !out_ready)
                chk(!in_ready, "R9 ready under stall", longint'(in_ready), 0);
        end
    end

    task automatic add_line(input int w, input bit first);
        for (int i = 0; i < w; i++) begin
            qy.push_back(int'($urandom % 65536));
            qcb.push_back(int'($urandom % 65536));
            qcr.push_back(int'($urandom % 65536));
            qsof.push_back(first && i == 0);
            qeol.push_back(i == w - 1);
        end
        exp_words += (w + 1) / 2;
    endtask

    task automatic add_frame(input int w, input int lines);
        for (int l = 0; l < lines; l++) add_line(w, l == 0);
    endtask

    task automatic run_seg(input string tag);
        running = 1;
        do @(negedge clk); while (!(pidx == qy.size() && e_data.size() == 0 && !out_valid));
        running = 0;
        @(negedge clk);
        chk(got_words == exp_words, {"R5 word count ", tag}, got_words, exp_words);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1; cfg_depth = 2'd3;
        in_valid = 0; in_y = 0; in_cb = 0; in_cr = 0; in_sof = 0; in_eol = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        @(negedge clk); #3;
        chk(out_valid == 0, "R10 out_valid", longint'(out_valid), 0);
        chk(err_odd == 0, "R10 err_odd", longint'(err_odd), 0);
        chk(in_ready == 1, "R10 in_ready", longint'(in_ready), 1);

        cfg_depth = 2'd3; add_frame(8, 4); run_seg("d16");          // R1
        cfg_depth = 2'd0; add_frame(6, 3); run_seg("d8");           // R2
        cfg_depth = 2'd1; add_frame(4, 2); run_seg("d10");          // R3 sof resets to Cb
        cfg_depth = 2'd2; add_frame(10, 2); run_seg("d12");
        cfg_depth = 2'd3; add_frame(2, 3); run_seg("min width");
        chk(err_odd == 0, "R8 no false error", longint'(err_odd), 0);

        // odd-length line inside a frame
        add_line(4, 1); add_line(3, 0); add_line(4, 0);
        run_seg("odd line");
        chk(err_odd == 1, "R8 error set", longint'(err_odd), 1);
        repeat (5) @(negedge clk);
        chk(err_odd == 1, "R8 error sticky", longint'(err_odd), 1);

        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk); rst = 0;
        #3;
        chk(err_odd == 0, "R10 err after reset", longint'(err_odd), 0);
        chk(out_valid == 0, "R10 valid after reset", longint'(out_valid), 0);

        cfg_depth = 2'd0; add_frame(4, 2); run_seg("after reset");   // R6 first word after reset

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule